// File: doc/BRIEF.md
# Code-Rate Acquisition Search Sequencer

This block drives the code-rate acquisition search for a convolutional decoder in a satellite QPSK receiver. A six-bit enable vector picks which of six puncturing rates the receiver may try. A start index picks the rate tried first. The sequencer then tries the enabled rates one at a time. For each trial it holds a request to the decoder and names the rate under test. It then waits a programmable number of cycles for the lock detector to answer. When no lock arrives, it moves on to the next higher enabled rate, wrapping from the top rate back to the lowest enabled one. The search goes on until lock is found or the search is restarted.

A broadcast-mode input of two bits can take over rate selection. While either bit is set, the software enable vector is ignored and a fixed alternate rate set, given by a parameter, is searched in its place. The outcome of the search appears on status outputs for the host to read: a lock flag, the rate that locked, and a sticky fault flag. The fault flag reports that the active rate set was empty. A restart pulse, or any change to the enable vector or to the broadcast-mode state, clears the status and begins a fresh search.

Top module: `cr_search_seq`

## Requirements
- R1: During reset and right after it, `trial_req_o`, `stat_locked_o`, `stat_err_o` and `stat_rate_o` are all 0. The first trial starts on the first clock edge at which `rst_ni` is high.
- R2: Rate index i (0 to 5, ascending code rate) is enabled by bit i of the active set. `trial_rate_o` only ever names an enabled rate. With exactly one bit set, only that rate is ever tried.
- R3: The first trial of a search uses the lowest enabled index at or above `start_idx_i`, wrapping to index 0. A start value of 6 or 7 is treated as 0. A change to `start_idx_i` alone does not restart the search.
- R4: Without lock, each trial keeps `trial_req_o` high with an unchanged rate for max(`dwell_i`,1) cycles. The next trial then begins in the very next cycle, at the next higher enabled index, wrapping from 5 to the lowest enabled index.
- R5: When `lock_i` is high in a trial cycle, in the next cycle `trial_req_o` is 0, `stat_locked_o` is 1 and `stat_rate_o` holds the rate that locked. This holds until a restart.
- R6: `lock_i` has no effect outside a trial: it neither sets `stat_locked_o` nor changes `stat_rate_o`.
- R7: If the active set is all zero when a search begins, no trial is issued and `stat_err_o` goes to 1 one cycle later. It stays 1 until a restart.
- R8: While `alt_mode_i` is non-zero, the active set is the parameter `ALT_MASK` (default bits 0, 1 and 4), and `rate_mask_i` is ignored.
- R9: A `restart_i` pulse, or a change of `rate_mask_i` or of the broadcast-mode state (`alt_mode_i` non-zero or zero) while a search is under way, makes the next cycle a restart cycle. In that cycle `trial_req_o`, `stat_locked_o`, `stat_err_o` and `stat_rate_o` are 0, and a new search begins the cycle after. A restart wins over a simultaneous lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_mask_i | input | 6 | Enable bit per code rate, bit i for rate index i |
| start_idx_i | input | 3 | Rate index tried first |
| alt_mode_i | input | 2 | Broadcast-mode bits; either set selects the fixed alternate set |
| dwell_i | input | 16 | Trial length in cycles (0 behaves as 1) |
| restart_i | input | 1 | Synchronous search restart |
| lock_i | input | 1 | Lock indication from the decoder |
| trial_req_o | output | 1 | A trial is in progress |
| trial_rate_o | output | 3 | Rate index under trial |
| stat_locked_o | output | 1 | Search ended in lock |
| stat_rate_o | output | 3 | Rate index that locked |
| stat_err_o | output | 1 | Sticky fault: empty rate set |

## Verification
A corrupted dwell counter shows as a trial boundary that comes early or late: the rate output steps one cycle off from a reference that counts dwell cycles on its own. A wrong rate-picker result shows at the first trial after a restart, or at the first wrap past index 5, as a disabled or out-of-order rate. A stale change-detect register shows as a missed or extra restart cycle in the request output within one cycle of an enable-vector edit. A status register that fails to clear or to hold shows in the lock and fault outputs in the cycle after a restart or a lock.

// File: rtl/cr_search_pkg.sv
package cr_search_pkg;

    typedef enum logic [1:0] {
        SQ_START  = 2'd0,
        SQ_TRIAL  = 2'd1,
        SQ_LOCKED = 2'd2,
        SQ_FAULT  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/cr_rate_pick.sv
// Finds the first set bit of mask_i at or above from_i, wrapping to 0.
module cr_rate_pick #(
    parameter int NUM_RATES = 6,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_RATES-1:0] mask_i,
    input  logic [IDX_W-1:0]     from_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin : pick_p
        int base;
        int j;
        base = (int'(from_i) >= NUM_RATES) ? 0 : int'(from_i);
        found_o = |mask_i;
        idx_o = '0;
        // scan from the largest offset down so the smallest offset wins
        for (int off = NUM_RATES - 1; off >= 0; off--) begin
            j = (base + off) % NUM_RATES;
            if (mask_i[j[IDX_W-1:0]]) begin
                idx_o = j[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cr_change_det.sv
// Flags a change of the enable vector or of the broadcast-mode state.
module cr_change_det #(
    parameter int NUM_RATES = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_RATES-1:0] mask_i,
    input  logic                 alt_i,
    output logic                 changed_o
);

    logic [NUM_RATES-1:0] mask_d, mask_q;
    logic                 alt_d, alt_q;

    always_comb begin
        mask_d    = mask_i;
        alt_d     = alt_i;
        changed_o = (mask_i != mask_q) || (alt_i != alt_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            alt_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            alt_q  <= alt_d;
        end
    end

endmodule

// File: rtl/cr_search_seq.sv
module cr_search_seq
    import cr_search_pkg::*;
#(
    parameter int                   NUM_RATES = 6,
    parameter int                   IDX_W     = 3,
    parameter int                   DWELL_W   = 16,
    parameter logic [NUM_RATES-1:0] ALT_MASK  = NUM_RATES'(6'b010011)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_RATES-1:0] rate_mask_i,
    input  logic [IDX_W-1:0]     start_idx_i,
    input  logic [1:0]           alt_mode_i,
    input  logic [DWELL_W-1:0]   dwell_i,
    input  logic                 restart_i,
    input  logic                 lock_i,
    output logic                 trial_req_o,
    output logic [IDX_W-1:0]     trial_rate_o,
    output logic                 stat_locked_o,
    output logic [IDX_W-1:0]     stat_rate_o,
    output logic                 stat_err_o
);

    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [DWELL_W:0] CNT_ONE = (DWELL_W + 1)'(1);

    typedef struct packed {
        sq_state_e          st;
        logic [IDX_W-1:0]   rate;
        logic [DWELL_W-1:0] cnt;
        logic               locked;
        logic [IDX_W-1:0]   lrate;
        logic               err;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        st: SQ_START, rate: '0, cnt: '0, locked: 1'b0, lrate: '0, err: 1'b0
    };

    seq_s cur_q, nxt_d;

    logic                 alt_act;
    logic [NUM_RATES-1:0] eff_mask;
    logic                 chg;
    logic                 first_found, adv_found;
    logic [IDX_W-1:0]     first_idx, adv_idx, adv_from;
    logic                 dwell_done;

    assign alt_act  = |alt_mode_i;
    assign eff_mask = alt_act ? ALT_MASK : rate_mask_i;
    assign adv_from = cur_q.rate + IDX_ONE;

    cr_change_det #(.NUM_RATES(NUM_RATES)) u_chg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mask_i    (rate_mask_i),
        .alt_i     (alt_act),
        .changed_o (chg)
    );

    cr_rate_pick #(.NUM_RATES(NUM_RATES), .IDX_W(IDX_W)) u_pick_first (
        .mask_i  (eff_mask),
        .from_i  (start_idx_i),
        .found_o (first_found),
        .idx_o   (first_idx)
    );

    cr_rate_pick #(.NUM_RATES(NUM_RATES), .IDX_W(IDX_W)) u_pick_next (
        .mask_i  (eff_mask),
        .from_i  (adv_from),
        .found_o (adv_found),
        .idx_o   (adv_idx)
    );

    always_comb begin
        dwell_done = ({1'b0, cur_q.cnt} + CNT_ONE) >= {1'b0, dwell_i};
        nxt_d = cur_q;
        case (cur_q.st)
            SQ_START: begin
                if (!first_found) begin
                    nxt_d.st  = SQ_FAULT;
                    nxt_d.err = 1'b1;
                end else begin
                    nxt_d.st   = SQ_TRIAL;
                    nxt_d.rate = first_idx;
                    nxt_d.cnt  = '0;
                end
            end
            SQ_TRIAL: begin
                if (lock_i) begin
                    nxt_d.st     = SQ_LOCKED;
                    nxt_d.locked = 1'b1;
                    nxt_d.lrate  = cur_q.rate;
                end else if (dwell_done) begin
                    nxt_d.cnt = '0;
                    if (adv_found) begin
                        nxt_d.rate = adv_idx;
                    end else begin
                        nxt_d.st  = SQ_FAULT;
                        nxt_d.err = 1'b1;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d = cur_q;
            end
        endcase
        if (restart_i || (cur_q.st != SQ_START && chg)) begin
            nxt_d.st     = SQ_START;
            nxt_d.cnt    = '0;
            nxt_d.locked = 1'b0;
            nxt_d.lrate  = '0;
            nxt_d.err    = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= SEQ_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign trial_req_o   = (cur_q.st == SQ_TRIAL);
    assign trial_rate_o  = cur_q.rate;
    assign stat_locked_o = cur_q.locked;
    assign stat_rate_o   = cur_q.lrate;
    assign stat_err_o    = cur_q.err;

endmodule

// File: rtl/cr_search_chk.sv
module cr_search_chk #(
    parameter int                   NUM_RATES = 6,
    parameter int                   IDX_W     = 3,
    parameter logic [NUM_RATES-1:0] ALT_MASK  = NUM_RATES'(6'b010011)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_RATES-1:0] rate_mask_i,
    input logic [1:0]           alt_mode_i,
    input logic                 restart_i,
    input logic                 lock_i,
    input logic                 trial_req_o,
    input logic [IDX_W-1:0]     trial_rate_o,
    input logic                 stat_locked_o,
    input logic [IDX_W-1:0]     stat_rate_o,
    input logic                 stat_err_o
);

    logic                 alt_a;
    logic [NUM_RATES-1:0] eff_m;
    logic [NUM_RATES-1:0] rate_bit;

    assign alt_a    = |alt_mode_i;
    assign eff_m    = alt_a ? ALT_MASK : rate_mask_i;
    assign rate_bit = NUM_RATES'(1) << trial_rate_o;

    // R2 / R8: a trial only runs on a rate of the set in force
    a_r2_rate_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trial_req_o |-> (($past(eff_m) & rate_bit) != '0));

    // R5: lock during an undisturbed trial ends the search with that rate
    a_r5_lock_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trial_req_o && lock_i && !restart_i
         && (rate_mask_i == $past(rate_mask_i)) && (alt_a == $past(alt_a)))
        |=> (stat_locked_o && !trial_req_o && (stat_rate_o == $past(trial_rate_o))));

    // R5: no trial is requested while locked
    a_r5_locked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_locked_o |-> !trial_req_o);

    // R7: a fault excludes trials and lock
    a_r7_fault_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_err_o |-> (!trial_req_o && !stat_locked_o));

    // R9: restart clears the status in the next cycle
    a_r9_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (!stat_locked_o && !stat_err_o && !trial_req_o && (stat_rate_o == '0)));

endmodule

bind cr_search_seq cr_search_chk #(
    .NUM_RATES (NUM_RATES),
    .IDX_W     (IDX_W),
    .ALT_MASK  (ALT_MASK)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rate_mask_i   (rate_mask_i),
    .alt_mode_i    (alt_mode_i),
    .restart_i     (restart_i),
    .lock_i        (lock_i),
    .trial_req_o   (trial_req_o),
    .trial_rate_o  (trial_rate_o),
    .stat_locked_o (stat_locked_o),
    .stat_rate_o   (stat_rate_o),
    .stat_err_o    (stat_err_o)
);

// File: tb/sim_cr_search_seq.sv
`timescale 1ns/1ps
module sim_cr_search_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  mask;
    logic [2:0]  start;
    logic [1:0]  alt;
    logic [15:0] dwell;
    logic        restart;
    logic        lock;
    logic        req;
    logic [2:0]  rate;
    logic        locked;
    logic [2:0]  lrate;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int   ph;          // 0 restart cycle, 1 trial, 2 locked, 3 fault
    int   m_rate, m_cnt, m_lrate;
    bit   m_lock, m_err;
    logic [5:0] p_mask;
    bit   p_alt;

    localparam logic [5:0] ALT_SET = 6'b010011;

    always #2 clk = ~clk;   // 250 MHz

    cr_search_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .rate_mask_i(mask), .start_idx_i(start),
        .alt_mode_i(alt), .dwell_i(dwell), .restart_i(restart), .lock_i(lock),
        .trial_req_o(req), .trial_rate_o(rate), .stat_locked_o(locked),
        .stat_rate_o(lrate), .stat_err_o(err)
    );

    function automatic int first_en(logic [5:0] m, int from);
        int b = (from >= 6) ? 0 : from;
        for (int off = 0; off < 6; off++) begin
            if (m[(b + off) % 6]) return (b + off) % 6;
        end
        return -1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [5:0] set_now;
        bit a_now;
        int len;
        a_now   = (alt != 2'b00);
        set_now = a_now ? ALT_SET : mask;
        len     = (dwell == 0) ? 1 : int'(dwell);
        if (!rst_n) begin
            ph = 0; m_rate = 0; m_cnt = 0; m_lrate = 0; m_lock = 0; m_err = 0;
            p_mask = '0; p_alt = 0;
            return;
        end
        if (restart || (ph != 0 && (mask != p_mask || a_now != p_alt))) begin
            ph = 0; m_lock = 0; m_err = 0; m_lrate = 0;
        end else if (ph == 0) begin
            if (first_en(set_now, int'(start)) < 0) begin
                ph = 3; m_err = 1;
            end else begin
                ph = 1; m_rate = first_en(set_now, int'(start)); m_cnt = 0;
            end
        end else if (ph == 1) begin
            if (lock) begin
                ph = 2; m_lock = 1; m_lrate = m_rate;
            end else if (m_cnt + 1 >= len) begin
                m_rate = first_en(set_now, m_rate + 1); m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        p_mask = mask; p_alt = a_now;
    endtask

    task automatic compare();
        check("R4 trial request vs model", int'(req), (ph == 1) ? 1 : 0);
        if (ph == 1 && req) check("R4 trial rate vs model", int'(rate), m_rate);
        check("R5 lock flag vs model", int'(locked), int'(m_lock));
        check("R5 locked rate vs model", int'(lrate), m_lrate);
        check("R7 fault flag vs model", int'(err), int'(m_err));
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        rst_n = 0; mask = 6'h3F; start = 3'd2; alt = 2'b00; dwell = 16'd3;
        restart = 0; lock = 0;
        tick(2);
        check("R1 reset request", int'(req), 0);
        check("R1 reset lock flag", int'(locked), 0);
        check("R1 reset fault", int'(err), 0);
        check("R1 reset locked rate", int'(lrate), 0);
        rst_n = 1;
        tick(1);
        check("R1 first trial after reset", int'(req), 1);
        check("R3 first rate from start", int'(rate), 2);
        tick(3);
        check("R4 advance after dwell", int'(rate), 3);
        lock = 1; tick(1); lock = 0;
        check("R5 lock flag", int'(locked), 1);
        check("R5 locked rate", int'(lrate), 3);
        check("R5 request dropped", int'(req), 0);
        tick(3);
        lock = 1; tick(1); lock = 0;
        check("R6 lock while locked", int'(lrate), 3);
        tick(1);
        restart = 1; tick(1); restart = 0;
        check("R9 restart clears lock", int'(locked), 0);
        check("R9 restart drops request", int'(req), 0);
        tick(1);
        check("R9 new search at start", int'(rate), 2);
        mask = 6'b010000; start = 3'd1;
        tick(2);
        check("R2 single rate", int'(rate), 4);
        tick(10);
        check("R2 single rate held", int'(rate), 4);
        check("R2 single rate request", int'(req), 1);
        mask = 6'b000101; start = 3'd3;
        tick(2);
        check("R3 disabled start wraps", int'(rate), 0);
        tick(3);
        check("R4 next enabled", int'(rate), 2);
        tick(3);
        check("R4 wrap to lowest", int'(rate), 0);
        start = 3'd7; tick(1);
        check("R3 start change alone keeps search", int'(req), 1);
        mask = 6'b100100;
        tick(2);
        check("R3 start 7 as 0", int'(rate), 2);
        mask = 6'b000000;
        tick(1);
        check("R9 mask change clears", int'(req), 0);
        tick(1);
        check("R7 empty set fault", int'(err), 1);
        check("R7 no trial", int'(req), 0);
        tick(5);
        check("R7 fault sticky", int'(err), 1);
        restart = 1; tick(1); restart = 0;
        check("R9 restart clears fault", int'(err), 0);
        tick(1);
        check("R7 fault again", int'(err), 1);
        mask = 6'b100000; alt = 2'b10; start = 3'd2;
        tick(2);
        check("R8 alternate set", int'(rate), 4);
        tick(3);
        check("R8 alternate wrap", int'(rate), 0);
        mask = 6'b000001;
        tick(2);
        check("R8 mask ignored", int'(rate), 4);
        alt = 2'b01; tick(1);
        check("R8 other mode bit same state", int'(req), 1);
        alt = 2'b00; dwell = 16'd0;
        tick(2);
        check("R8 mode off uses mask", int'(rate), 0);
        mask = 6'h3F; start = 3'd0;
        tick(2);
        check("R4 dwell 0 first", int'(rate), 0);
        tick(1);
        check("R4 dwell 0 step", int'(rate), 1);
        tick(1);
        check("R4 dwell 0 step 2", int'(rate), 2);
        lock = 1; restart = 1; tick(1); lock = 0; restart = 0;
        check("R9 restart beats lock", int'(locked), 0);
        lock = 1; tick(1); lock = 0;
        check("R6 lock in restart cycle", int'(locked), 0);
        check("R6 trial starts", int'(req), 1);
        dwell = 16'd5;
        tick(20);
        lock = 1; tick(1); lock = 0;
        check("R5 lock after long run", int'(locked), 1);
        tick(3);
        done = 1;
        report();
    end

endmodule